// File: doc/BRIEF.md
# Asynchronous Byte-Queue Parallel Port

This block lets an external controller exchange bytes with on-chip logic over an 8-bit parallel bus that carries no clock. Two byte queues, 16 entries each, sit behind the bus. The receive queue is filled by internal logic and emptied by the controller. The transmit queue is filled by the controller and emptied by internal logic.

The controller reads by pulsing an active-low read strobe. The falling edge takes the next byte from the receive queue, and the port drives that byte onto the bus for as long as the strobe stays low. The controller writes by pulsing an active-high write strobe. The byte on the bus is stored in the transmit queue when the strobe falls.

Two active-low flags tell the controller when each transfer is allowed. Both strobes and the bus are brought into the block clock through two-flop synchronisers before any edge is detected. Two sticky bits record a write to a full queue and a read from an empty queue. A synchronous active-low reset returns the block to its idle state.

Top module: `parbus_fifo_port`

## Requirements
- R1: Two rising clock edges with `rst_n` low leave both queues empty. After them, `rx_avail_n` reads 1, `tx_room_n` reads 0, `out_valid` reads 0, `in_ready` reads 1, and `overflow_flag` and `underflow_flag` read 0.
- R2: `rx_avail_n` is 0 only when the receive queue holds at least one byte and the synchronised read strobe is high. It reads 1 from the clock edge at which a read pulse is seen until that pulse has ended and been synchronised.
- R3: Each falling edge of `ext_rd_n` removes the oldest byte from the receive queue. While `ext_rd_n` stays low, the port drives that byte on `ext_data`. The byte is valid at most 4 clock cycles after the falling edge.
- R4: While `ext_rd_n` is high, the port does not drive `ext_data`. A value driven on the bus by the controller reads back unchanged.
- R5: Each falling edge of `ext_wr` stores the byte on `ext_data` in the transmit queue, in arrival order. The oldest stored byte appears on `out_data` while `out_valid` is 1.
- R6: `tx_room_n` is 1 exactly when the transmit queue holds 16 bytes.
- R7: A falling edge of `ext_wr` while the transmit queue is full stores nothing and sets `overflow_flag`. `overflow_flag` then stays 1 until reset.
- R8: A falling edge of `ext_rd_n` while the receive queue is empty drives 0x00 on `ext_data` and sets `underflow_flag`. `underflow_flag` then stays 1 until reset.
- R9: `in_ready` is 1 while the receive queue holds fewer than 16 bytes. A clock edge with `in_valid` and `in_ready` both 1 appends `in_data`. `in_valid` while `in_ready` is 0 has no effect. A clock edge with `out_take` and `out_valid` both 1 removes the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr | input | 1 | External write strobe, active high, stores on its falling edge |
| ext_data | inout | 8 | Bidirectional parallel data bus |
| rx_avail_n | output | 1 | Low when a byte may be read |
| tx_room_n | output | 1 | Low when a byte may be written |
| in_valid | input | 1 | Internal side offers a byte for the receive queue |
| in_data | input | 8 | Byte offered to the receive queue |
| in_ready | output | 1 | Receive queue can accept a byte |
| out_valid | output | 1 | Transmit queue holds a byte |
| out_data | output | 8 | Oldest byte in the transmit queue |
| out_take | input | 1 | Internal side removes the oldest transmit byte |
| overflow_flag | output | 1 | Sticky: a write arrived while the transmit queue was full |
| underflow_flag | output | 1 | Sticky: a read arrived while the receive queue was empty |

## Verification
The assertions check four things on every cycle: the transmit-full flag against an occupancy count kept outside the design, that the overflow bit rises only on a write to a full queue, that both sticky bits stay set, and that the receive flag is never low while the receive queue is empty. Other behaviours can be shown only by the bench's scenarios: the byte order through each queue, the byte seen on the bus after a read edge, the 0x00 returned on an underflow read, the bus being released while the read strobe is high, and the receive flag staying high for the length of a read pulse.

// File: rtl/parbus_pkg.sv
// Package parbus_pkg
// Shared defaults and the edge-event type used by the parallel byte port.
// Assumes: nothing beyond IEEE 1800-2017.
package parbus_pkg;
    localparam int DEF_WIDTH  = 8;
    localparam int DEF_DEPTH  = 16;
    localparam int DEF_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/parbus_strobe_sync.sv
// Module parbus_strobe_sync
// Brings one asynchronous strobe into the clock domain through STAGES flops.
// It reports the synchronised level and a one-cycle pulse for each edge.
// Assumes: STAGES >= 2. IDLE is the strobe's inactive level, loaded at reset.
module parbus_strobe_sync
    import parbus_pkg::*;
#(
    parameter int   STAGES = DEF_STAGES,
    parameter logic IDLE   = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  async_in,
    output logic  level,
    output edge_t edges
);
    logic [STAGES:0] chain;

    // Shift register: the synchroniser stages plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {(STAGES + 1){IDLE}};
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    // Compare the newest synchronised sample with the one before it.
    always_comb begin
        level      = chain[STAGES-1];
        edges.rise = chain[STAGES-1] & ~chain[STAGES];
        edges.fall = chain[STAGES] & ~chain[STAGES-1];
    end
endmodule

// File: rtl/parbus_bus_sync.sv
// Module parbus_bus_sync
// Carries the data bus through the same number of flops as the strobes.
// A byte seen with a write edge was therefore sampled at the same instant as the strobe.
// Assumes: the controller holds the bus stable around the write strobe's falling edge.
module parbus_bus_sync
    import parbus_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out
);
    logic [WIDTH-1:0] stage [STAGES];

    // One register per stage, chained by a generate loop.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the pins directly.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= bus_in;
            end
        end else begin : g_next
            // Later stages copy the stage before them.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign bus_out = stage[STAGES-1];
endmodule

// File: rtl/parbus_queue.sv
// Module parbus_queue
// Synchronous first-in first-out byte store. Push and pop may happen in the same cycle.
// Assumes: DEPTH is a power of two. The caller never pushes when full and never pops when empty.
module parbus_queue
    import parbus_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr;
    logic [AW:0]      rptr;

    // Pointer update. The extra top bit tells full apart from empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    // Storage write. No reset: a location is only read after it has been written.
    always_ff @(posedge clk) begin
        if (push) mem[wptr[AW-1:0]] <= push_data;
    end

    // Status and head-of-queue view.
    always_comb begin
        head  = mem[rptr[AW-1:0]];
        empty = (wptr == rptr);
        full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    end
endmodule

// File: rtl/parbus_fifo_port.sv
// Module parbus_fifo_port (top)
// Device side of an unclocked 8-bit parallel bus with two byte queues behind it.
// Read strobe: active low, pops on its falling edge, drives the bus while low.
// Write strobe: active high, stores the bus byte on its falling edge.
// Assumes: strobe pulses and gaps last at least STAGES+2 clock cycles, and the
// controller waits STAGES+2 cycles after the read strobe falls before it samples the bus.
module parbus_fifo_port
    import parbus_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rd_n,
    input  logic             ext_wr,
    inout  wire  [WIDTH-1:0] ext_data,
    output logic             rx_avail_n,
    output logic             tx_room_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_take,
    output logic             overflow_flag,
    output logic             underflow_flag
);
    logic             rd_level;
    logic             wr_level;
    edge_t            rd_edges;
    edge_t            wr_edges;
    logic [WIDTH-1:0] bus_sampled;
    logic [WIDTH-1:0] rd_byte;
    logic [WIDTH-1:0] rx_head;
    logic             rx_empty;
    logic             rx_full;
    logic             rx_push;
    logic             rx_pop;
    logic             tx_empty;
    logic             tx_full;
    logic             tx_push;
    logic             tx_pop;

    parbus_strobe_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_rd_n), .level(rd_level), .edges(rd_edges)
    );

    parbus_strobe_sync #(.STAGES(STAGES), .IDLE(1'b0)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_wr), .level(wr_level), .edges(wr_edges)
    );

    parbus_bus_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .bus_in(ext_data), .bus_out(bus_sampled)
    );

    parbus_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(in_data),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    parbus_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_sampled),
        .pop(tx_pop), .head(out_data), .empty(tx_empty), .full(tx_full)
    );

    // Queue control: gate every push and pop by the queue state.
    always_comb begin
        rx_push = in_valid & ~rx_full;
        rx_pop  = rd_edges.fall & ~rx_empty;
        tx_push = wr_edges.fall & ~tx_full;
        tx_pop  = out_take & ~tx_empty;
    end

    // Read byte latch: take the queue head on a read edge, or 0 when the queue is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)             rd_byte <= '0;
        else if (rd_edges.fall) rd_byte <= rx_empty ? '0 : rx_head;
    end

    // Sticky error bits, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_flag  <= 1'b0;
            underflow_flag <= 1'b0;
        end else begin
            if (wr_edges.fall && tx_full)  overflow_flag  <= 1'b1;
            if (rd_edges.fall && rx_empty) underflow_flag <= 1'b1;
        end
    end

    // Bus driver: on only while the raw read strobe is low.
    assign ext_data = ext_rd_n ? {WIDTH{1'bz}} : rd_byte;

    // Flags and internal-side status.
    always_comb begin
        rx_avail_n = rx_empty | ~rd_level;
        tx_room_n  = tx_full;
        in_ready   = ~rx_full;
        out_valid  = ~tx_empty;
    end
endmodule

// File: rtl/parbus_fifo_port_chk.sv
// Module parbus_fifo_port_chk
// Assertion checker bound to parbus_fifo_port. It keeps its own count of
// transmit-queue occupancy from the push and pop events.
// Assumes: it is attached with the bind statement at the end of this file.
module parbus_fifo_port_chk #(
    parameter int DEPTH = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_push,
    input logic out_take,
    input logic out_valid,
    input logic tx_room_n,
    input logic rx_avail_n,
    input logic rx_empty,
    input logic overflow_flag,
    input logic underflow_flag
);
    localparam int CW = $clog2(DEPTH) + 1;
    logic [CW-1:0] tx_count;

    // Independent occupancy count of the transmit queue.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_count <= '0;
        else        tx_count <= tx_count + CW'(tx_push) - CW'(out_take & out_valid);
    end

    assert_room_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_room_n == (tx_count == CW'(DEPTH)));

    assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_flag) |-> $past(tx_room_n));

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag);

    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_flag |=> underflow_flag);

    assert_avail_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail_n |-> !rx_empty);
endmodule

bind parbus_fifo_port parbus_fifo_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .out_take(out_take),
    .out_valid(out_valid), .tx_room_n(tx_room_n), .rx_avail_n(rx_avail_n),
    .rx_empty(rx_empty), .overflow_flag(overflow_flag), .underflow_flag(underflow_flag)
);

// File: tb/sim_parbus_fifo_port.sv
// Bench for parbus_fifo_port: a table-driven loop followed by directed tests.
module sim_parbus_fifo_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr = 1'b0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_byte = 8'h00;
    wire  [7:0] bus;
    logic       rx_avail_n, tx_room_n, in_ready, out_valid;
    logic       overflow_flag, underflow_flag;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_take = 1'b0;
    logic [7:0] out_data;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    assign bus = tb_oe ? tb_byte : 8'hzz;

    always #2 clk = ~clk;

    parbus_fifo_port u0 (
        .clk(clk), .rst_n(rst_n), .ext_rd_n(rd_n), .ext_wr(wr), .ext_data(bus),
        .rx_avail_n(rx_avail_n), .tx_room_n(tx_room_n), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_take(out_take), .overflow_flag(overflow_flag),
        .underflow_flag(underflow_flag)
    );

    // Each entry: {byte pushed internally and read back, byte written externally and taken}.
    localparam logic [15:0] VECS [6] = '{16'h3C_C3, 16'h00_FF, 16'hA5_5A, 16'h81_7E, 16'hFF_00, 16'h12_ED};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_in(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        wait_cyc(1);
        in_valid = 1'b0;
    endtask

    // Read pulse: check the bus while RD# is low, then release.
    task automatic ext_read(input logic [7:0] exp, input string req);
        rd_n = 1'b0;
        wait_cyc(6);
        chk(req, bus, exp);
        rd_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic ext_write(input logic [7:0] b);
        tb_byte = b;
        tb_oe   = 1'b1;
        wait_cyc(1);
        wr = 1'b1;
        wait_cyc(5);
        wr = 1'b0;
        wait_cyc(5);
        tb_oe = 1'b0;
    endtask

    task automatic take_out(input logic [7:0] exp, input string req);
        chk({req, " valid"}, {7'd0, out_valid}, 8'd1);
        chk(req, out_data, exp);
        out_take = 1'b1;
        wait_cyc(1);
        out_take = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 rx_avail_n", {7'd0, rx_avail_n}, 8'd1);
        chk("R1 tx_room_n", {7'd0, tx_room_n}, 8'd0);
        chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
        chk("R1 in_ready", {7'd0, in_ready}, 8'd1);
        chk("R1 flags", {6'd0, overflow_flag, underflow_flag}, 8'd0);

        // Table loop: R3 and R5 under several patterns
        foreach (VECS[i]) begin
            push_in(VECS[i][15:8]);
            chk("R2 avail after push", {7'd0, rx_avail_n}, 8'd0);
            ext_read(VECS[i][15:8], "R3 read byte");
            ext_write(VECS[i][7:0]);
            take_out(VECS[i][7:0], "R5 written byte");
        end

        // R4: the bus is released while RD# is high
        tb_byte = 8'hA5;
        tb_oe   = 1'b1;
        wait_cyc(1);
        chk("R4 bus released", bus, 8'hA5);
        tb_oe = 1'b0;

        // R2: the flag stays high during the whole read pulse, then falls
        push_in(8'h11);
        push_in(8'h22);
        rd_n = 1'b0;
        wait_cyc(6);
        chk("R2 high during pulse", {7'd0, rx_avail_n}, 8'd1);
        chk("R3 first of two", bus, 8'h11);
        rd_n = 1'b1;
        wait_cyc(5);
        chk("R2 low after pulse", {7'd0, rx_avail_n}, 8'd0);
        ext_read(8'h22, "R3 second of two");
        chk("R2 high when empty", {7'd0, rx_avail_n}, 8'd1);

        // R9: fill the receive queue, an extra push is dropped
        for (int k = 0; k < 16; k++) push_in(8'h40 + 8'(k));
        chk("R9 in_ready when full", {7'd0, in_ready}, 8'd0);
        push_in(8'hEE);
        for (int k = 0; k < 16; k++) ext_read(8'h40 + 8'(k), "R9 rx order");
        chk("R8 no underflow yet", {7'd0, underflow_flag}, 8'd0);

        // R8: a read from the empty queue returns 0x00 and sets the sticky bit
        ext_read(8'h00, "R8 empty read byte");
        chk("R8 underflow set", {7'd0, underflow_flag}, 8'd1);
        push_in(8'h77);
        ext_read(8'h77, "R8 queue unchanged");
        chk("R8 underflow sticky", {7'd0, underflow_flag}, 8'd1);

        // R6 and R7: fill the transmit queue, then overflow it
        for (int k = 0; k < 15; k++) ext_write(8'h80 + 8'(k));
        chk("R6 not full at 15", {7'd0, tx_room_n}, 8'd0);
        ext_write(8'h8F);
        chk("R6 full at 16", {7'd0, tx_room_n}, 8'd1);
        chk("R7 no overflow yet", {7'd0, overflow_flag}, 8'd0);
        ext_write(8'hDD);
        chk("R7 overflow set", {7'd0, overflow_flag}, 8'd1);
        for (int k = 0; k < 16; k++) take_out(8'h80 + 8'(k), "R7 tx order");
        chk("R7 extra write dropped", {7'd0, out_valid}, 8'd0);
        chk("R6 room after drain", {7'd0, tx_room_n}, 8'd0);
        chk("R7 overflow sticky", {7'd0, overflow_flag}, 8'd1);

        // R1: reset clears the sticky bits and the queues
        push_in(8'h99);
        ext_write(8'h55);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 flags after reset", {6'd0, overflow_flag, underflow_flag}, 8'd0);
        chk("R1 rx empty after reset", {7'd0, rx_avail_n}, 8'd1);
        chk("R1 tx empty after reset", {7'd0, out_valid}, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule